// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block sits between a set of pending interrupt lines and a processor core. It gates the pending lines with a mask and picks the most urgent of the remaining lines. It raises a request to the core only when that line's level is strictly above the level the core is currently running at. Source `i` runs at level `i+1`. Level 0 is ordinary code. The highest index is the most urgent. With the default four sources, the order from most to least urgent is: index 3 for a bus fault, index 2 for an illegal instruction or address trap, index 1 for fast I/O, and index 0 for slow I/O.

When the core acknowledges, the block saves the running level and moves the running level up to that of the accepted source. From then on, only strictly higher sources can interrupt. Nesting can only climb, so the save area needs one slot per level and no more. When a handler finishes, the core pulses end-of-handler. The saved level is then restored, and any pending source above the restored level is presented at once.

Top module: `prio_nest_arb`

## Requirements
- R1: After reset, `run_lvl` is 0 and `irq` is low.
- R2: A source is a candidate only when both its `pend` bit and its `mask` bit are 1. A pending source whose mask bit is 0 never raises `irq`.
- R3: When there are several candidates, `src_idx` names the one with the highest index. With four sources, index 3 wins over 2, 2 over 1, and 1 over 0.
- R4: `irq` is high only when the winner's level (`src_idx`+1) is strictly greater than `run_lvl`. A candidate at the same level or a lower level does not raise it.
- R5: `ack` while `irq` is high sets `run_lvl` to `src_idx`+1 on the next cycle and saves the old level.
- R6: `ack` while `irq` is low leaves `run_lvl` unchanged.
- R7: `eoh` while `run_lvl` > 0 restores the saved level on the next cycle. In that same cycle, `irq` is raised if a candidate lies above the restored level.
- R8: `eoh` while `run_lvl` is 0 leaves `run_lvl` at 0.
- R9: When `eoh` and `ack` are both high in the same cycle, the pop is performed and `ack` is ignored.
- R10: At level 0 every candidate raises `irq`. At the top level (`run_lvl` equals the source count) no candidate does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend | input | NSRC | Pending interrupt lines |
| mask | input | NSRC | Per-source enable bits |
| ack | input | 1 | Core accepts the presented request |
| eoh | input | 1 | Current handler has finished |
| irq | output | 1 | Request to the core |
| src_idx | output | $clog2(NSRC) | Index of the winning candidate |
| run_lvl | output | $clog2(NSRC+1) | Current running level |

## Verification
A corrupted save slot has no effect until the matching pop. At that point `run_lvl` takes a wrong value one cycle after `eoh`, so the bench unwinds every nesting chain level by level and checks each restored value. A wrong running level shows up on `irq` in the same cycle as the fault. The bench catches it by probing sources just at, just below and just above the current level.

// File: rtl/prio_nest_arb.sv
module prio_nest_arb #(
  parameter int NSRC = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0]           pend,
  input  logic [NSRC-1:0]           mask,
  input  logic                      ack,
  input  logic                      eoh,
  output logic                      irq,
  output logic [$clog2(NSRC)-1:0]   src_idx,
  output logic [$clog2(NSRC+1)-1:0] run_lvl
);
  localparam int IW = $clog2(NSRC);
  localparam int LW = $clog2(NSRC+1);

  logic [NSRC-1:0] cand;
  logic [IW-1:0]   win;
  logic [LW-1:0]   win_lvl;
  logic [LW-1:0]   slot [NSRC];
  logic            take, pop;

  assign cand = pend & mask;

  always_comb begin
    win = '0;
    for (int i = 0; i < NSRC; i++)
      if (cand[i]) win = IW'(i);
  end

  assign win_lvl = LW'(win) + LW'(1);
  assign irq     = (|cand) && (win_lvl > run_lvl);
  assign src_idx = win;
  assign pop     = eoh && (run_lvl != '0);
  assign take    = ack && irq && !eoh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_lvl <= '0;
      for (int i = 0; i < NSRC; i++) slot[i] <= '0;
    end else if (pop) begin
      run_lvl <= slot[run_lvl - LW'(1)];
    end else if (take) begin
      slot[win] <= run_lvl;
      run_lvl   <= win_lvl;
    end
  end

  a_r2_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend[src_idx] && mask[src_idx]));
  a_r3_highest: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((cand >> (int'(src_idx) + 1)) == '0));
  a_r5_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !eoh) |=> (run_lvl == LW'($past(src_idx)) + LW'(1)));
  a_r6_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq && !eoh) |=> $stable(run_lvl));
  a_r7_pop_down: assert property (@(posedge clk) disable iff (!rst_n)
    (eoh && run_lvl != '0) |=> (run_lvl < $past(run_lvl)));
  a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (eoh && run_lvl == '0) |=> (run_lvl == '0));
  a_r10_top_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (run_lvl == LW'(NSRC)) |-> !irq);
endmodule

// File: tb/test_prio_nest_arb.sv
module test_prio_nest_arb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pend = '0, mask = '0;
  logic ack = 0, eoh = 0;
  logic irq;
  logic [1:0] src_idx;
  logic [2:0] run_lvl;
  int errors = 0, checks = 0;
  bit done = 0;

  prio_nest_arb #(.NSRC(N)) i_prio_nest_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask), .ack(ack), .eoh(eoh),
    .irq(irq), .src_idx(src_idx), .run_lvl(run_lvl));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(); #1; endtask

  task automatic step(logic a, logic e);
    ack = a; eoh = e;
    @(posedge clk); @(negedge clk);
    ack = 0; eoh = 0; #1;
  endtask

  task automatic t_reset();
    chk("R1 level", run_lvl, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_mask();
    pend = 4'b0010; mask = 4'b1101; settle();
    chk("R2 masked irq", irq, 0);
    mask = 4'b1111; settle();
    chk("R2 unmasked irq", irq, 1);
    chk("R2 idx", src_idx, 1);
    pend = '0; settle();
  endtask

  task automatic t_priority();
    pend = 4'b1111; mask = 4'b1111; settle();
    chk("R3 top idx", src_idx, 3);
    chk("R10 irq at level0", irq, 1);
    mask = 4'b0111; settle();
    chk("R3 next idx", src_idx, 2);
    mask = 4'b0011; settle();
    chk("R3 idx1", src_idx, 1);
    pend = '0; mask = 4'b1111; settle();
  endtask

  task automatic t_nest();
    pend = 4'b0001; settle();
    step(1, 0);
    chk("R5 level1", run_lvl, 1);
    chk("R4 same level", irq, 0);
    pend = 4'b0100; settle();
    chk("R4 higher irq", irq, 1);
    step(1, 0);
    chk("R5 level3", run_lvl, 3);
    pend = 4'b0010; settle();
    chk("R4 lower irq", irq, 0);
    pend = 4'b1000; settle();
    step(1, 0);
    chk("R5 level4", run_lvl, 4);
    pend = 4'b1111; settle();
    chk("R10 top quiet", irq, 0);
    step(0, 1);
    chk("R7 pop to 3", run_lvl, 3);
    chk("R7 re-present irq", irq, 1);
    chk("R7 re-present idx", src_idx, 3);
    pend = '0; settle();
    step(0, 1);
    chk("R7 pop to 1", run_lvl, 1);
    step(0, 1);
    chk("R7 pop to 0", run_lvl, 0);
  endtask

  task automatic t_idle_ack();
    pend = '0; settle();
    step(1, 0);
    chk("R6 ack no irq", run_lvl, 0);
  endtask

  task automatic t_empty_pop();
    step(0, 1);
    chk("R8 empty pop", run_lvl, 0);
    pend = 4'b0001; settle();
    step(1, 0);
    chk("R8 stack intact push", run_lvl, 1);
    pend = '0; settle();
    step(0, 1);
    chk("R8 stack intact pop", run_lvl, 0);
  endtask

  task automatic t_both();
    pend = 4'b0010; settle();
    step(1, 0);
    chk("R9 setup", run_lvl, 2);
    pend = 4'b1000; settle();
    step(1, 1);
    chk("R9 pop wins", run_lvl, 0);
    pend = '0; settle();
  endtask

  initial begin
    @(negedge clk); #1;
    t_reset();
    rst_n = 1;
    @(negedge clk); #1;
    t_mask();
    t_priority();
    t_nest();
    t_idle_ack();
    t_empty_pop();
    t_both();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule